// File: doc/BRIEF.md
# 8-bit ALU with Status Register

This block is the data path of an 8-bit accumulator processor. A combinational unit takes an operation code, a register operand (the accumulator or an index register, steered in by the caller), a memory operand and the current status byte. It produces a result byte and the status byte that the operation would leave behind. A processor status register, held in the block, feeds the current flags back into the unit. It loads the new status byte on a rising clock edge, but only when the flag-write enable is high.

The status byte holds carry in bit 0, zero in bit 1, interrupt mask in bit 2, decimal in bit 3, break in bit 4, overflow in bit 6 and negative in bit 7. Bit 5 has no flag. The decimal flag is stored but does not change arithmetic. Instruction decode, address generation and write-back of the result are left to the caller. Operations that must not write back (compare, bit test, flag operations) return the register operand unchanged on the result output.

Top module: `alu8_status`

## Requirements
- R1: While reset is asserted and after it is released, the status register holds 0x24 until the first enabled write. The bit layout is C=0, Z=1, I=2, D=3, B=4, V=6, N=7.
- R2: Op 0 (add) returns A+M+C mod 256. C is bit 8 of the sum. V is set when A and M have equal sign bits and the result's sign differs from A. Z and N follow the result.
- R3: Op 1 (subtract) returns A−M−(1−C) mod 256. C is set when no borrow occurs. V is set when A and M differ in sign and the result's sign differs from A. The D flag has no effect.
- R4: Op 2 (compare) sets C when A≥M and sets Z and N from the 8-bit difference. V is kept and the result output equals the register operand.
- R5: Ops 3, 4 and 5 (AND, OR, XOR of A and M) and op 13 (pass M, used for loads and transfers) return their value and update only Z and N.
- R6: Op 6 (bit test) sets Z when A AND M is zero, copies M bit 7 to N and M bit 6 to V, and keeps C. The result output equals the register operand.
- R7: Ops 7, 8, 9 and 10 shift A left, shift A right, rotate A left and rotate A right. A left move puts A bit 7 into C, and a right move puts A bit 0 into C. Rotates fill the vacated bit with the old C and shifts fill it with 0. Z and N follow the result.
- R8: Ops 11 and 12 increment and decrement A modulo 256, update only Z and N, and never change C or V.
- R9: Op 14 sets and op 15 clears the status bits selected by M, but only within the mask 0x4D (C, I, D, V). All other bits are ignored. The result equals A.
- R10: Op 16 (restore from stack) makes the status byte (M OR 0x30) minus 0x10, so bit 5 reads 1 and bit 4 reads 0. The result equals A.
- R11: The status register takes the computed status byte on a clock edge only when flag_we is high, and otherwise holds its value. Codes 17 to 31 return A and leave the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 5 | Operation code |
| reg_opnd | input | 8 | Register operand (A) |
| mem_opnd | input | 8 | Memory operand or mask (M) |
| flag_we | input | 1 | Status register write enable |
| res_out | output | 8 | Result byte |
| status_nxt | output | 8 | Status byte produced by the current operation |
| status_q | output | 8 | Registered processor status |

## Verification
The assertions check on every cycle that the status register moves only on an enabled edge and then takes the computed byte. They also check that increment and decrement keep C and V, that bit test copies the operand's top bits and leaves the result alone, that compare keeps V, and that a restored status byte has bit 5 set and bit 4 clear. Only the bench's scenarios can show that the sums, borrows, overflow corners, shift fills and flag masks carry the right numeric values. For that, a behavioural reference model runs alongside directed corner vectors and a long random sequence.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW = 8;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FI = 2;
  localparam int FD = 3;
  localparam int FB = 4;
  localparam int FU = 5;
  localparam int FV = 6;
  localparam int FN = 7;
  localparam logic [DW-1:0] FLAG_OP_MASK = 8'h4D;

  typedef enum logic [4:0] {
    OP_ADC = 5'd0, OP_SBC = 5'd1, OP_CMP = 5'd2, OP_AND = 5'd3,
    OP_ORA = 5'd4, OP_EOR = 5'd5, OP_BIT = 5'd6, OP_ASL = 5'd7,
    OP_LSR = 5'd8, OP_ROL = 5'd9, OP_ROR = 5'd10, OP_INC = 5'd11,
    OP_DEC = 5'd12, OP_PASS = 5'd13, OP_FSET = 5'd14, OP_FCLR = 5'd15,
    OP_RSTR = 5'd16
  } alu_op_e;

  typedef enum logic [1:0] {CL_ARITH, CL_BITS, CL_FLAG, CL_NONE} op_class_e;

  function automatic op_class_e op_class(input logic [4:0] op);
    if (op <= 5'd2) return CL_ARITH;
    else if (op <= 5'd13) return CL_BITS;
    else if (op <= 5'd16) return CL_FLAG;
    else return CL_NONE;
  endfunction

  // returns {carry, overflow, result}
  function automatic logic [DW+1:0] add8(input logic [DW-1:0] a, m, input logic cin);
    logic [DW:0] s;
    s = {1'b0, a} + {1'b0, m} + {{DW{1'b0}}, cin};
    return {s[DW], ~(a[DW-1] ^ m[DW-1]) & (a[DW-1] ^ s[DW-1]), s[DW-1:0]};
  endfunction

  // carry is inverted borrow
  function automatic logic [DW+1:0] sub8(input logic [DW-1:0] a, m, input logic cin);
    logic [DW:0] d;
    d = {1'b0, a} - {1'b0, m} - {{DW{1'b0}}, ~cin};
    return {~d[DW], (a[DW-1] ^ m[DW-1]) & (a[DW-1] ^ d[DW-1]), d[DW-1:0]};
  endfunction

  function automatic logic [DW-1:0] set_zn(input logic [DW-1:0] st, input logic [DW-1:0] r);
    logic [DW-1:0] o;
    o = st;
    o[FZ] = (r == '0);
    o[FN] = r[DW-1];
    return o;
  endfunction
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
(
  input  logic [4:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] m,
  input  logic [DW-1:0] st_in,
  output logic [DW-1:0] res,
  output logic [DW-1:0] st_out
);
  logic [DW+1:0] sum_w, dif_w, cmp_w;

  assign sum_w = add8(a, m, st_in[FC]);
  assign dif_w = sub8(a, m, st_in[FC]);
  assign cmp_w = sub8(a, m, 1'b1);

  always_comb begin
    res    = a;
    st_out = st_in;
    case (op)
      OP_ADC: begin
        res = sum_w[DW-1:0];
        st_out = set_zn(st_in, res);
        st_out[FC] = sum_w[DW+1];
        st_out[FV] = sum_w[DW];
      end
      OP_SBC: begin
        res = dif_w[DW-1:0];
        st_out = set_zn(st_in, res);
        st_out[FC] = dif_w[DW+1];
        st_out[FV] = dif_w[DW];
      end
      OP_CMP: begin
        st_out = set_zn(st_in, cmp_w[DW-1:0]);
        st_out[FC] = cmp_w[DW+1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
(
  input  logic [4:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] m,
  input  logic [DW-1:0] st_in,
  output logic [DW-1:0] res,
  output logic [DW-1:0] st_out
);
  logic shift_left, shift_right, rot_in;

  assign shift_left  = (op == OP_ASL) || (op == OP_ROL);
  assign shift_right = (op == OP_LSR) || (op == OP_ROR);
  assign rot_in      = ((op == OP_ROL) || (op == OP_ROR)) ? st_in[FC] : 1'b0;

  always_comb begin
    res = a;
    case (op)
      OP_AND:  res = a & m;
      OP_ORA:  res = a | m;
      OP_EOR:  res = a ^ m;
      OP_INC:  res = a + 8'd1;
      OP_DEC:  res = a - 8'd1;
      OP_PASS: res = m;
      OP_ASL, OP_ROL: res = {a[DW-2:0], rot_in};
      OP_LSR, OP_ROR: res = {rot_in, a[DW-1:1]};
      default: res = a;
    endcase

    if (op == OP_BIT) begin
      st_out = st_in;
      st_out[FZ] = ((a & m) == '0);
      st_out[FN] = m[DW-1];
      st_out[FV] = m[DW-2];
    end else begin
      st_out = set_zn(st_in, res);
      if (shift_left)  st_out[FC] = a[DW-1];
      if (shift_right) st_out[FC] = a[0];
    end
  end
endmodule

// File: rtl/alu8_flagops.sv
module alu8_flagops
  import alu8_pkg::*;
(
  input  logic [4:0]    op,
  input  logic [DW-1:0] m,
  input  logic [DW-1:0] st_in,
  output logic [DW-1:0] st_out
);
  logic [DW-1:0] sel_bits;
  assign sel_bits = m & FLAG_OP_MASK;

  always_comb begin
    case (op)
      OP_FSET: st_out = st_in | sel_bits;
      OP_FCLR: st_out = st_in & ~sel_bits;
      OP_RSTR: st_out = (m | 8'h30) - 8'h10;
      default: st_out = st_in;
    endcase
  end
endmodule

// File: rtl/alu8_status_reg.sv
module alu8_status_reg
  import alu8_pkg::*;
#(
  parameter logic [DW-1:0] INIT = 8'h24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= INIT;
    else if (we) q <= d;
  end
endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
#(
  parameter logic [7:0] STATUS_INIT = 8'h24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] op_sel,
  input  logic [7:0] reg_opnd,
  input  logic [7:0] mem_opnd,
  input  logic       flag_we,
  output logic [7:0] res_out,
  output logic [7:0] status_nxt,
  output logic [7:0] status_q
);
  logic [DW-1:0] ar_res, ar_st, bt_res, bt_st, fl_st;
  op_class_e     cls;

  assign cls = op_class(op_sel);

  alu8_arith u_arith (.op(op_sel), .a(reg_opnd), .m(mem_opnd), .st_in(status_q),
                      .res(ar_res), .st_out(ar_st));
  alu8_bitops u_bits (.op(op_sel), .a(reg_opnd), .m(mem_opnd), .st_in(status_q),
                      .res(bt_res), .st_out(bt_st));
  alu8_flagops u_flag (.op(op_sel), .m(mem_opnd), .st_in(status_q), .st_out(fl_st));

  always_comb begin
    case (cls)
      CL_ARITH: begin res_out = ar_res;   status_nxt = ar_st;    end
      CL_BITS:  begin res_out = bt_res;   status_nxt = bt_st;    end
      CL_FLAG:  begin res_out = reg_opnd; status_nxt = fl_st;    end
      default:  begin res_out = reg_opnd; status_nxt = status_q; end
    endcase
  end

  alu8_status_reg #(.INIT(STATUS_INIT)) u_psr (
    .clk(clk), .rst_n(rst_n), .we(flag_we), .d(status_nxt), .q(status_q));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> status_q == $past(status_q));
  assert_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> status_q == $past(status_nxt));
  assert_incdec_cv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_INC || op_sel == OP_DEC) |->
      (status_nxt[FC] == status_q[FC] && status_nxt[FV] == status_q[FV]));
  assert_bit_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == OP_BIT |-> (status_nxt[FN] == mem_opnd[7] &&
      status_nxt[FV] == mem_opnd[6] && res_out == reg_opnd));
  assert_cmp_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == OP_CMP |-> (res_out == reg_opnd && status_nxt[FV] == status_q[FV]));
  assert_restore_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == OP_RSTR |-> (status_nxt[FU] && !status_nxt[FB]));
endmodule

// File: tb/tb_alu8_status.sv
`timescale 1ns/1ps
module tb_alu8_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] op_sel = '0;
  logic [7:0] reg_opnd = '0, mem_opnd = '0;
  logic       flag_we = 1'b0;
  logic [7:0] res_out, status_nxt, status_q;
  int n_chk = 0, n_bad = 0;
  logic [7:0] model_st;
  bit done = 0;

  always #2.5 clk = ~clk;

  alu8_status dut (.clk(clk), .rst_n(rst_n), .op_sel(op_sel), .reg_opnd(reg_opnd),
    .mem_opnd(mem_opnd), .flag_we(flag_we), .res_out(res_out),
    .status_nxt(status_nxt), .status_q(status_q));

  function automatic string tag(int op);
    case (op)
      0: return "R2";  1: return "R3";  2: return "R4";  6: return "R6";
      3, 4, 5, 13: return "R5";
      7, 8, 9, 10: return "R7";
      11, 12: return "R8";
      14, 15: return "R9";
      16: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic ref_step(input int op, input logic [7:0] a, m, st,
                          output logic [7:0] r, output logic [7:0] ns);
    int t;
    bit set_zn = 1;
    r = a; ns = st;
    case (op)
      0: begin t = a + m + st[0]; r = t[7:0]; ns[0] = (t > 255);
               ns[6] = (((a ^ r) & (m ^ r) & 8'h80) != 0); end
      1: begin t = int'(a) - int'(m) - (1 - int'(st[0])); r = t[7:0]; ns[0] = (t >= 0);
               ns[6] = (((a ^ m) & (a ^ r) & 8'h80) != 0); end
      2: begin t = int'(a) - int'(m); ns[0] = (t >= 0); ns[1] = (t[7:0] == 0);
               ns[7] = t[7]; set_zn = 0; end
      3: r = a & m;
      4: r = a | m;
      5: r = a ^ m;
      6: begin ns[1] = ((a & m) == 0); ns[7] = m[7]; ns[6] = m[6]; set_zn = 0; end
      7: begin r = a << 1; ns[0] = a[7]; end
      8: begin r = a >> 1; ns[0] = a[0]; end
      9: begin r = (a << 1) | {7'd0, st[0]}; ns[0] = a[7]; end
      10: begin r = (a >> 1) | {st[0], 7'd0}; ns[0] = a[0]; end
      11: r = a + 8'd1;
      12: r = a - 8'd1;
      13: r = m;
      14: begin ns = st | (m & 8'b0100_1101); set_zn = 0; end
      15: begin ns = st & ~(m & 8'b0100_1101); set_zn = 0; end
      16: begin ns = (m | 8'h20) & 8'hEF; set_zn = 0; end
      default: set_zn = 0;
    endcase
    if (set_zn) begin ns[1] = (r == 0); ns[7] = r[7]; end
  endtask

  task automatic check8(input string req, input string what, input logic [7:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic apply(input int op, input logic [7:0] a, m, input bit we);
    logic [7:0] er, es;
    @(negedge clk);
    op_sel = op[4:0]; reg_opnd = a; mem_opnd = m; flag_we = we;
    #1;
    ref_step(op, a, m, model_st, er, es);
    check8(tag(op), "result", res_out, er);
    check8(tag(op), "status_nxt", status_nxt, es);
    @(posedge clk);
    if (we) model_st = es;
    @(negedge clk);
    flag_we = 1'b0;
    check8("R11", "status_q", status_q, model_st);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_st = 8'h24;
    repeat (3) @(negedge clk);
    check8("R1", "status during reset", status_q, 8'h24);
    rst_n = 1'b1;
    @(negedge clk);
    check8("R1", "status after reset", status_q, 8'h24);
    // R2 corners: signed overflow, carry out to zero
    apply(15, 8'h00, 8'h01, 1);
    apply(0, 8'h7F, 8'h01, 1);
    apply(14, 8'h00, 8'h01, 1);
    apply(0, 8'hFF, 8'h00, 1);
    apply(0, 8'h50, 8'h50, 0);
    // R3 corners, with decimal set
    apply(14, 8'h00, 8'h08, 1);
    apply(1, 8'h80, 8'h01, 1);
    apply(15, 8'h00, 8'h01, 1);
    apply(1, 8'h00, 8'h00, 1);
    // R4 compare equal/less/greater
    apply(2, 8'h40, 8'h40, 1);
    apply(2, 8'h10, 8'h20, 1);
    apply(2, 8'hF0, 8'h20, 1);
    // R5 logic and pass
    apply(3, 8'hF0, 8'h0F, 1);
    apply(4, 8'h80, 8'h01, 1);
    apply(5, 8'hAA, 8'hAA, 1);
    apply(13, 8'h00, 8'h9C, 1);
    // R6 bit test
    apply(6, 8'h01, 8'hC0, 1);
    apply(6, 8'hFF, 8'h3F, 1);
    // R7 shifts with C set then clear
    apply(14, 8'h00, 8'h01, 1);
    apply(9, 8'h80, 8'h00, 1);
    apply(10, 8'h01, 8'h00, 1);
    apply(7, 8'h81, 8'h00, 1);
    apply(8, 8'h01, 8'h00, 1);
    // R8 wrap
    apply(14, 8'h00, 8'h41, 1);
    apply(11, 8'hFF, 8'h00, 1);
    apply(12, 8'h00, 8'h00, 1);
    // R9 mask limits
    apply(14, 8'h00, 8'hFF, 1);
    apply(15, 8'h00, 8'hFF, 1);
    // R10 restore
    apply(16, 8'h00, 8'h00, 1);
    apply(16, 8'h00, 8'hFF, 1);
    apply(16, 8'h00, 8'h10, 1);
    // R11 hold and unused codes
    apply(0, 8'h01, 8'h01, 0);
    apply(20, 8'h33, 8'h44, 1);
    apply(31, 8'h5A, 8'hFF, 1);
    for (int i = 0; i < 3000; i++)
      apply($urandom_range(0, 31), 8'($urandom), 8'($urandom), bit'($urandom_range(0, 3) != 0));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule